// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register File

This block is the software-visible register bank of an Ethernet DMA engine. A word-indexed write/read port (index = byte address shifted right by two) reaches the bus mode word, the receive and transmit descriptor list bases, the two current descriptor pointers, the operation control word, the interrupt enable mask and the interrupt status word. A constant version word sits at a fixed low index.

Hardware event pulses set status bits. Software clears them by writing ones. A single level interrupt is raised while any enabled status bit is set. A write to the transmit poll index stores nothing: it produces a one-cycle strobe that tells the transmit descriptor engine to start. Writing a list base also seeds the matching current descriptor pointer. The receive and transmit enable bits of the control word and both current pointers are brought out to the engine.

Top module: `eth_dma_csr`

## Requirements
- R1: After reset every stored register reads 0, irq_o, tx_poll_o, rx_en_o and tx_en_o are low, and the version index still reads 0x1012.
- R2: A write to the status index (0x3C5) clears each status bit whose written data bit is 1. Bits written as 0 keep their value.
- R3: A high bit of evt_i sets the same bit of the status word at the next clock edge. If a clearing write to that bit lands in the same cycle, the bit ends up set.
- R4: A write to the poll index (0x3C1) drives tx_poll_o high for exactly the one cycle after the write edge. The index stores nothing and reads 0.
- R5: A write to the receive list base (0x3C3) stores the data there and in the current receive pointer (0x3D3). A write to the transmit list base (0x3C4) does the same for the current transmit pointer (0x3D2).
- R6: A write to bus mode (0x3C0) stores the data with bit 0 forced to 0.
- R7: The version index (0x008) always reads 0x1012, and writes to it have no effect.
- R8: irq_o is high exactly when the status word ANDed with the interrupt enable word (0x3C7) is nonzero. It follows every write and every event from the next clock edge.
- R9: rx_en_o equals bit 1 and tx_en_o equals bit 13 of the control word (0x3C6).
- R10: Indexes at or above 0x400, and indexes below it that are not mapped, read 0. Writes to them change no register.
- R11: The control word, the enable mask and both current pointers store and return full 32-bit words. A register that is not written keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the current index |
| addr_i | input | 14 | Byte address. Bits 13:2 form the register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_i | input | 32 | Hardware status set pulses, one per status bit |
| irq_o | output | 1 | Level interrupt |
| tx_poll_o | output | 1 | One-cycle transmit poll strobe |
| rx_en_o | output | 1 | Receive enable (control bit 1) |
| tx_en_o | output | 1 | Transmit enable (control bit 13) |
| cur_rx_desc_o | output | 32 | Current receive descriptor pointer |
| cur_tx_desc_o | output | 32 | Current transmit descriptor pointer |

## Verification
The bench targets an event and a clearing write to the same status bit in one cycle. A design that let the clear win would lose an interrupt cause, and the bit would read 0. It also checks that the poll strobe drops after one cycle and reads back as 0: a design that stored the poll write, or held the strobe, would show a nonzero read or a second strobe. Base writes are checked through the pointer index and port, which catches a design that loads only one of the pair. Writes to the version word, to unmapped indexes and to indexes at or above 0x400 are followed by reads of every register, which exposes any decode that aliases into the mapped bank.

// File: rtl/eth_dma_csr_pkg.sv
package eth_dma_csr_pkg;
  localparam int unsigned IDX_VER    = 'h008;
  localparam int unsigned IDX_BUS    = 'h3C0;
  localparam int unsigned IDX_POLL   = 'h3C1;
  localparam int unsigned IDX_RXBASE = 'h3C3;
  localparam int unsigned IDX_TXBASE = 'h3C4;
  localparam int unsigned IDX_STAT   = 'h3C5;
  localparam int unsigned IDX_CTRL   = 'h3C6;
  localparam int unsigned IDX_IEN    = 'h3C7;
  localparam int unsigned IDX_TXPTR  = 'h3D2;
  localparam int unsigned IDX_RXPTR  = 'h3D3;

  localparam int unsigned RX_EN_BIT = 1;
  localparam int unsigned TX_EN_BIT = 13;

  localparam logic [31:0] VERSION_WORD = 32'h0000_1012;

  typedef struct packed {
    logic ver;
    logic bus;
    logic poll;
    logic rxb;
    logic txb;
    logic stat;
    logic ctrl;
    logic ien;
    logic txp;
    logic rxp;
  } csr_sel_t;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
  import eth_dma_csr_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  output csr_sel_t         rd_sel_o,
  output csr_sel_t         wr_sel_o
);
  csr_sel_t hit;

  always_comb begin
    hit      = '0;
    hit.ver  = (idx_i == IDX_W'(IDX_VER));
    hit.bus  = (idx_i == IDX_W'(IDX_BUS));
    hit.poll = (idx_i == IDX_W'(IDX_POLL));
    hit.rxb  = (idx_i == IDX_W'(IDX_RXBASE));
    hit.txb  = (idx_i == IDX_W'(IDX_TXBASE));
    hit.stat = (idx_i == IDX_W'(IDX_STAT));
    hit.ctrl = (idx_i == IDX_W'(IDX_CTRL));
    hit.ien  = (idx_i == IDX_W'(IDX_IEN));
    hit.txp  = (idx_i == IDX_W'(IDX_TXPTR));
    hit.rxp  = (idx_i == IDX_W'(IDX_RXPTR));
  end

  assign rd_sel_o = hit;
  assign wr_sel_o = we_i ? hit : '0;

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(rd_sel_o)); // R10
    AST_RD_WR_AGREE: assert ((wr_sel_o & ~rd_sel_o) == '0); // R10
  end
endmodule

// File: rtl/csr_word_reg.sv
module csr_word_reg #(
  parameter int unsigned       DATA_W = 32,
  parameter logic [DATA_W-1:0] WMASK  = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (ld_i) q_q <= d_i & WMASK;
  end

  assign q_o = q_q;

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == ($past(d_i) & WMASK))); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o)); // R11
endmodule

// File: rtl/csr_status.sv
module csr_status #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] evt_i,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] stat_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic clr;
    assign clr = clr_wr_i & wdata_i[b];

    // event set beats a same-cycle software clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[b] <= 1'b0;
      else if (evt_i[b]) stat_q[b] <= 1'b1;
      else if (clr)      stat_q[b] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[b] |=> stat_q[b]); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr && !evt_i[b]) |=> !stat_q[b]); // R2
    AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr && !evt_i[b]) |=> $stable(stat_q[b])); // R2
  end

  assign status_o = stat_q;
endmodule

// File: rtl/eth_dma_csr.sv
module eth_dma_csr
  import eth_dma_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 12,
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] evt_i,
  output logic              irq_o,
  output logic              tx_poll_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic [DATA_W-1:0] cur_rx_desc_o,
  output logic [DATA_W-1:0] cur_tx_desc_o
);
  localparam logic [DATA_W-1:0] BUS_WMASK = ~DATA_W'(1);

  logic [IDX_W-1:0]  idx;
  csr_sel_t          rd_sel, wr_sel;
  logic [DATA_W-1:0] bus_q, rxb_q, txb_q, ctrl_q, ien_q, rxp_q, txp_q, stat_q;
  logic              poll_q;
  logic              unused_sink;

  assign idx = addr_i[ADDR_W-1:2];
  assign unused_sink = ^{addr_i[1:0], wr_sel.ver, rd_sel.poll};

  csr_addr_dec #(.IDX_W(IDX_W)) u_dec (
    .we_i     (we_i),
    .idx_i    (idx),
    .rd_sel_o (rd_sel),
    .wr_sel_o (wr_sel)
  );

  csr_word_reg #(.DATA_W(DATA_W), .WMASK(BUS_WMASK)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(wr_sel.bus), .d_i(wdata_i), .q_o(bus_q));
  csr_word_reg #(.DATA_W(DATA_W)) u_rxb (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(wr_sel.rxb), .d_i(wdata_i), .q_o(rxb_q));
  csr_word_reg #(.DATA_W(DATA_W)) u_txb (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(wr_sel.txb), .d_i(wdata_i), .q_o(txb_q));
  csr_word_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(wr_sel.ctrl), .d_i(wdata_i), .q_o(ctrl_q));
  csr_word_reg #(.DATA_W(DATA_W)) u_ien (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(wr_sel.ien), .d_i(wdata_i), .q_o(ien_q));
  // pointers load on a direct write or on a write to their list base
  csr_word_reg #(.DATA_W(DATA_W)) u_rxp (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(wr_sel.rxp | wr_sel.rxb), .d_i(wdata_i), .q_o(rxp_q));
  csr_word_reg #(.DATA_W(DATA_W)) u_txp (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(wr_sel.txp | wr_sel.txb), .d_i(wdata_i), .q_o(txp_q));

  csr_status #(.DATA_W(DATA_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_wr_i (wr_sel.stat),
    .wdata_i  (wdata_i),
    .evt_i    (evt_i),
    .status_o (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) poll_q <= 1'b0;
    else         poll_q <= wr_sel.poll;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_sel.ver)  rdata_o = DATA_W'(VERSION_WORD);
    if (rd_sel.bus)  rdata_o = bus_q;
    if (rd_sel.rxb)  rdata_o = rxb_q;
    if (rd_sel.txb)  rdata_o = txb_q;
    if (rd_sel.stat) rdata_o = stat_q;
    if (rd_sel.ctrl) rdata_o = ctrl_q;
    if (rd_sel.ien)  rdata_o = ien_q;
    if (rd_sel.rxp)  rdata_o = rxp_q;
    if (rd_sel.txp)  rdata_o = txp_q;
  end

  assign irq_o         = |(stat_q & ien_q);
  assign tx_poll_o     = poll_q;
  assign rx_en_o       = ctrl_q[RX_EN_BIT];
  assign tx_en_o       = ctrl_q[TX_EN_BIT];
  assign cur_rx_desc_o = rxp_q;
  assign cur_tx_desc_o = txp_q;

  AST_POLL_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_poll_o |-> $past(we_i && idx == IDX_W'(IDX_POLL))); // R4
  AST_RXBASE_SEEDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel.rxb |=> (cur_rx_desc_o == $past(wdata_i))); // R5
  AST_TXBASE_SEEDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel.txb |=> (cur_tx_desc_o == $past(wdata_i))); // R5
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_q != '0) && (ien_q != '0))); // R8
endmodule

// File: tb/eth_dma_csr_bench.sv
`timescale 1ns/1ps
module eth_dma_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] evt = '0;
  logic [31:0] rdata;
  logic        irq, tx_poll, rx_en, tx_en;
  logic [31:0] cur_rx, cur_tx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_bus, m_rxb, m_txb, m_stat, m_ctrl, m_ien, m_rxp, m_txp;

  always #2 clk = ~clk;

  eth_dma_csr u_eth_dma_csr (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .irq_o(irq), .tx_poll_o(tx_poll),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .cur_rx_desc_o(cur_rx), .cur_tx_desc_o(cur_tx));

  function automatic logic [31:0] exp_read(int unsigned idx);
    case (idx)
      'h008: return 32'h1012;
      'h3C0: return m_bus;
      'h3C3: return m_rxb;
      'h3C4: return m_txb;
      'h3C5: return m_stat;
      'h3C6: return m_ctrl;
      'h3C7: return m_ien;
      'h3D2: return m_txp;
      'h3D3: return m_rxp;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string idx_tag(int unsigned idx);
    case (idx)
      'h008: return "R7 version";
      'h3C0: return "R6 bus mode";
      'h3C1: return "R4 poll reads zero";
      'h3C3, 'h3C4: return "R5 list base";
      'h3C5: return "R2/R3 status";
      'h3C6, 'h3C7: return "R11 ctrl/ien";
      'h3D2, 'h3D3: return "R5/R11 pointer";
      default: return "R10 unmapped";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(logic w, int unsigned idx, logic [31:0] d, logic [31:0] ev);
    if (w) begin
      case (idx)
        'h3C0: m_bus = d & 32'hFFFF_FFFE;
        'h3C3: begin m_rxb = d; m_rxp = d; end
        'h3C4: begin m_txb = d; m_txp = d; end
        'h3C5: m_stat = m_stat & ~d;
        'h3C6: m_ctrl = d;
        'h3C7: m_ien = d;
        'h3D2: m_txp = d;
        'h3D3: m_rxp = d;
        default: ;
      endcase
    end
    m_stat = m_stat | ev;
  endtask

  task automatic step(logic w, int unsigned idx, logic [31:0] d, logic [31:0] ev);
    @(negedge clk);
    we = w; addr = {idx[11:0], 2'b00}; wdata = d; evt = ev;
    @(posedge clk); #1;
    apply(w, idx, d, ev);
    we = 1'b0; evt = '0; wdata = '0;
    check("R4 poll strobe", {31'b0, tx_poll}, {31'b0, (w && idx == 'h3C1)});
    check("R8 irq level", {31'b0, irq}, {31'b0, |(m_stat & m_ien)});
    check("R9 rx enable", {31'b0, rx_en}, {31'b0, m_ctrl[1]});
    check("R9 tx enable", {31'b0, tx_en}, {31'b0, m_ctrl[13]});
    check("R5 rx pointer port", cur_rx, m_rxp);
    check("R5 tx pointer port", cur_tx, m_txp);
  endtask

  task automatic read_chk(int unsigned idx);
    addr = {idx[11:0], 2'b00};
    #0.5;
    check(idx_tag(idx), rdata, exp_read(idx));
  endtask

  int unsigned idx_list [13] = '{'h008, 'h3C0, 'h3C1, 'h3C3, 'h3C4, 'h3C5, 'h3C6,
                                 'h3C7, 'h3D2, 'h3D3, 'h3C8, 'h400, 'hFFF};

  task automatic read_all();
    foreach (idx_list[k]) read_chk(idx_list[k]);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    {m_bus, m_rxb, m_txb, m_stat, m_ctrl, m_ien, m_rxp, m_txp} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #0.5;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 poll after reset", {31'b0, tx_poll}, 32'h0);
    check("R1 enables after reset", {30'b0, rx_en, tx_en}, 32'h0);
    read_all();

    // R3/R8 events raise status and irq through the mask (TI bit0, NIS bit16)
    step(1, 'h3C7, 32'h0000_0001, 32'h0);
    step(0, 0, 0, 32'h0001_0001);
    read_chk('h3C5);
    // R2 clear TI only; NIS remains, irq drops
    step(1, 'h3C5, 32'h0000_0001, 32'h0);
    read_chk('h3C5);
    // R3 RI (bit6) set and cleared in the same cycle: set wins
    step(1, 'h3C5, 32'h0000_0040, 32'h0000_0040);
    read_chk('h3C5);
    // R8 enable RU (bit7) and AIS (bit15) then raise RU
    step(1, 'h3C7, 32'h0000_8080, 32'h0);
    step(0, 0, 0, 32'h0000_8080);
    step(1, 'h3C5, 32'hFFFF_FFFF, 32'h0);
    read_chk('h3C5);
    // R6 bus mode bit 0 forced low
    step(1, 'h3C0, 32'hFFFF_FFFF, 32'h0);
    read_chk('h3C0);
    // R5 base writes seed pointers, then pointers written directly (R11)
    step(1, 'h3C3, 32'h1000_0040, 32'h0);
    step(1, 'h3C4, 32'h2000_0080, 32'h0);
    read_all();
    step(1, 'h3D3, 32'h1000_0060, 32'h0);
    read_chk('h3C3);
    read_chk('h3D3);
    // R4 poll strobe lasts one cycle, reads zero
    step(1, 'h3C1, 32'hDEAD_BEEF, 32'h0);
    read_chk('h3C1);
    step(0, 0, 0, 32'h0);
    // R9 control enables
    step(1, 'h3C6, 32'h0000_2002, 32'h0);
    step(1, 'h3C6, 32'h0000_0002, 32'h0);
    // R7 and R10 writes that must change nothing
    step(1, 'h008, 32'h5555_AAAA, 32'h0);
    step(1, 'h400, 32'hFFFF_FFFF, 32'h0);
    step(1, 'h3C8, 32'hFFFF_FFFF, 32'h0);
    step(1, 'hFFF, 32'hFFFF_FFFF, 32'h0);
    read_all();

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned ix;
      logic [31:0] ev;
      ix = idx_list[$urandom_range(0, 12)];
      ev = $urandom & $urandom & $urandom;
      step(($urandom_range(0, 3) != 0), ix, $urandom, ev);
      read_chk(idx_list[$urandom_range(0, 12)]);
    end
    read_all();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule